// File: doc/BRIEF.md
# Multi-Shift Byte Extractor

This block gathers arbitrary 8-bit fields out of 64-bit words. A wide data vector is cut into independent 64-bit words. A control vector of the same width supplies one selector byte for every output byte. Each output byte is the low byte of its word after a right rotation by the selector amount. Each word therefore yields eight independent field picks, and any field may straddle the top and bottom of the word.

A typical use is the field-splitting step of a binary-to-text encoder. There, each byte lane pulls a 6-bit group out of a packed 24-bit triple, and a later lookup uses only those six bits.

The result can be registered. In that case it is captured on a valid strobe and appears one clock later, together with an output valid. A parameter can instead make the path purely combinational.

Top module: `mshift_extract`

## Requirements
- R1: Output byte `8*i+j` (bits `64*i+8*j+7 : 64*i+8*j`) comes from data word `i` (bits `64*i+63 : 64*i`), steered by control byte `8*i+j` at the same bit position.
- R2: For a selector whose low six bits give amount `a` (0..63), output bit `k` (k = 0..7) of that byte equals bit `a+k` of the word.
- R3: Rotation wraps. When `a+k` exceeds 63, the bit is taken from word bit `a+k-64`. Amounts 57..63 therefore mix top and bottom bits of the word.
- R4: Bits 7:6 of every selector byte have no effect on the result.
- R5: The words are independent. Changing one data word alters only the eight output bytes of that word.
- R6: With the output register enabled, a strobe on `in_vld` at a clock edge loads the result computed from that edge's inputs. The result and `out_vld = 1` appear after that edge, and `out_vld` returns to 0 after the next edge unless it is strobed again.
- R7: While `in_vld` is low, `result` holds its last value whatever the data and control inputs do.
- R8: While `rst_n` is low, `result` is all zeros and `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Capture strobe for data and control |
| data_in | input | 64*WORDS | Data vector of 64-bit words |
| ctrl_in | input | 64*WORDS | Selector bytes, one per output byte |
| result | output | 64*WORDS | Extracted bytes |
| out_vld | output | 1 | High for one cycle after each capture |

## Verification
Two things can meet in a single byte lane. A wrapped extraction, with an amount of 57 to 63, can coincide with selector bytes whose ignored top bits are set. The sweep drives control bytes that step through all 256 values, so every amount appears both with and without the upper bits set. Each lane is judged against a bit-by-bit rotation model computed in the bench. A second pair of functions also meets in one cycle: a held result and new input values that arrive without a strobe. This case is provoked by changing the inputs with `in_vld` low and confirming that the previous result survives.

// File: rtl/mshift_extract.sv
module mshift_extract #(
  parameter int WORDS      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic [64*WORDS-1:0]   data_in,
  input  logic [64*WORDS-1:0]   ctrl_in,
  output logic [64*WORDS-1:0]   result,
  output logic                  out_vld
);
  localparam int VBITS = 64 * WORDS;

  logic [VBITS-1:0] picked;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [127:0] twice;
    assign twice = {data_in[w*64 +: 64], data_in[w*64 +: 64]};
    for (genvar b = 0; b < 8; b++) begin : g_byte
      logic [5:0]   amt;
      logic [127:0] shifted;
      assign amt     = ctrl_in[w*64 + b*8 +: 6];
      assign shifted = twice >> amt;
      assign picked[w*64 + b*8 +: 8] = shifted[7:0];
    end
  end

  if (REGISTERED) begin : g_reg
    logic [VBITS-1:0] res_q;
    logic             vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= in_vld;
        if (in_vld) res_q <= picked;
      end
    end
    assign result  = res_q;
    assign out_vld = vld_q;
  end else begin : g_comb
    assign result  = picked;
    assign out_vld = in_vld;
  end
endmodule

module mshift_extract_chk #(
  parameter int WORDS      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_vld,
  input logic [64*WORDS-1:0] data_in,
  input logic [64*WORDS-1:0] ctrl_in,
  input logic [64*WORDS-1:0] result,
  input logic                out_vld
);
  if (REGISTERED) begin : g_chk
    // R6
    vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == $past(in_vld));
    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_vld) |-> $stable(result));
    // R2
    zero_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_vld) && $past(ctrl_in[5:0]) == 6'd0) |-> result[7:0] == $past(data_in[7:0]));
    // R2
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_vld) && $past(ctrl_in[5:0]) == 6'd8) |-> result[7:0] == $past(data_in[15:8]));
    // R3
    wrap_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_vld) && $past(ctrl_in[5:0]) == 6'd60) |->
        result[7:0] == {$past(data_in[3:0]), $past(data_in[63:60])});
  end
endmodule

bind mshift_extract mshift_extract_chk #(.WORDS(WORDS), .REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .data_in(data_in),
  .ctrl_in(ctrl_in), .result(result), .out_vld(out_vld)
);

// File: tb/mshift_extract_test.sv
module mshift_extract_test;
  localparam int WORDS = 8;
  localparam int VB    = 64 * WORDS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [VB-1:0] data_in = '0;
  logic [VB-1:0] ctrl_in = '0;
  logic [VB-1:0] result;
  logic          out_vld;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  mshift_extract #(.WORDS(WORDS), .REGISTERED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .data_in(data_in),
    .ctrl_in(ctrl_in), .result(result), .out_vld(out_vld)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] ref_byte(input logic [63:0] w, input logic [7:0] s);
    logic [7:0] r;
    int a;
    a = s % 64;
    for (int k = 0; k < 8; k++) r[k] = w[(a + k) % 64];
    return r;
  endfunction

  function automatic logic [VB-1:0] rnd_vec();
    logic [VB-1:0] v;
    for (int i = 0; i < VB / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [VB-1:0] act, input logic [VB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [VB-1:0] d, input logic [VB-1:0] c);
    @(negedge clk);
    data_in = d; ctrl_in = c; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic check_all(input logic [VB-1:0] d, input logic [VB-1:0] c);
    for (int n = 0; n < VB / 8; n++) begin
      logic [7:0] e;
      logic [7:0] sel;
      sel = c[n*8 +: 8];
      e = ref_byte(d[(n/8)*64 +: 64], sel);
      n_chk++;
      if (result[n*8 +: 8] !== e) begin
        n_bad++;
        if (sel[5:0] > 6'd56)
          $display("FAIL R3 byte %0d: actual %h expected %h", n, result[n*8 +: 8], e);
        else
          $display("FAIL R1/R2 byte %0d: actual %h expected %h", n, result[n*8 +: 8], e);
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VB-1:0] d;
    logic [VB-1:0] c;
    logic [VB-1:0] r0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 result", result, '0);
    check("R8 out_vld", {{(VB-1){1'b0}}, out_vld}, '0);
    rst_n = 1'b1;

    // R1 R2 R3 R4: sweep every selector value across all lanes
    for (int t = 0; t < 256; t++) begin
      d = rnd_vec();
      for (int n = 0; n < VB / 8; n++) c[n*8 +: 8] = 8'((t + 37 * n) & 8'hFF);
      apply(d, c);
      // R6: valid one cycle after strobe
      check("R6 out_vld high", {{(VB-1){1'b0}}, out_vld}, {{(VB-1){1'b0}}, 1'b1});
      check_all(d, c);
    end

    // R2: walking single-one word with every amount
    for (int a = 0; a < 64; a++) begin
      d = '0;
      for (int w = 0; w < WORDS; w++) d[w*64 + a] = 1'b1;
      c = '0;
      for (int n = 0; n < VB / 8; n++) c[n*8 +: 8] = 8'((a + 64 - (n % 8)) % 64);
      apply(d, c);
      check_all(d, c);
    end

    // R4: upper selector bits ignored
    d = rnd_vec();
    c = rnd_vec();
    for (int n = 0; n < VB / 8; n++) c[n*8 +: 8] = {2'b00, c[n*8 +: 6]};
    apply(d, c);
    r0 = result;
    for (int n = 0; n < VB / 8; n++) c[n*8 + 6 +: 2] = 2'b11;
    apply(d, c);
    check("R4 upper bits set", result, r0);
    for (int n = 0; n < VB / 8; n++) c[n*8 + 6 +: 2] = 2'((n % 3) + 1);
    apply(d, c);
    check("R4 mixed upper bits", result, r0);

    // R5: change only word 3
    d[3*64 +: 64] = ~d[3*64 +: 64];
    apply(d, c);
    for (int w = 0; w < WORDS; w++)
      if (w != 3) check("R5 other words unchanged", {{(VB-64){1'b0}}, result[w*64 +: 64]},
                        {{(VB-64){1'b0}}, r0[w*64 +: 64]});
    check_all(d, c);

    // R6: valid drops after one cycle
    @(negedge clk);
    check("R6 out_vld low", {{(VB-1){1'b0}}, out_vld}, '0);

    // R7: inputs change without strobe, result held
    r0 = result;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      data_in = rnd_vec(); ctrl_in = rnd_vec();
      @(negedge clk);
      check("R7 hold", result, r0);
    end

    // R6: back-to-back strobes keep valid high and update each cycle
    d = rnd_vec(); c = rnd_vec();
    @(negedge clk);
    data_in = d; ctrl_in = c; in_vld = 1'b1;
    @(negedge clk);
    check_all(d, c);
    d = rnd_vec(); c = rnd_vec();
    data_in = d; ctrl_in = c;
    @(negedge clk);
    in_vld = 1'b0;
    check("R6 back-to-back valid", {{(VB-1){1'b0}}, out_vld}, {{(VB-1){1'b0}}, 1'b1});
    check_all(d, c);

    // R8: reset clears again
    rst_n = 1'b0;
    #1;
    check("R8 async clear", result, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule